// File: doc/BRIEF.md
# Transmit Queue with Low-Water Request

This block holds bytes that a host has written for transmission and hands them to a serial shifter one at a time. The host writes through a simple strobe. Only the low byte of each host word is kept. The shifter takes the oldest byte in any cycle in which it reports idle and the queue holds data.

The host programs a low-water level. This level counts the bytes still waiting in the queue, not the free slots. When the number of waiting bytes drops to that level or below, a ready status rises. The host can then write a burst of (depth minus level) bytes without checking again. For example, with a depth of 32 and a level of 8, the burst is 24 bytes.

A gated interrupt copies the ready status while its enable input is high. The host drops the enable while it services the queue and raises it again after refilling. An empty flag and the fill count are exported. A write that arrives while the queue is full is dropped and sets a sticky overflow flag.

Top module: `txLowWaterFifo`

## Requirements
- R1: After reset the fill count is 0, `empty` is 1, `overflow` is 0 and `popStrobe` is 0.
- R2: A write stores bits [7:0] of `wrData` and ignores the upper bits. Bytes leave on `popData` in the order they were written (first in, first out).
- R3: A write while the fill count equals the depth (32) is dropped. The count and the stored bytes are unchanged, and `overflow` becomes 1 one cycle later and stays 1 until reset.
- R4: The fill count `level` rises by one after an accepted write and falls by one after a pop. It is unchanged when both happen in the same cycle, and it never exceeds the depth.
- R5: `txReady` is 1 exactly when `level` is less than or equal to `thresh`, including at `thresh` = 0 and `thresh` = 32.
- R6: `txIrq` is 1 exactly when `txReady` is 1 and `irqEn` is 1. Changing `irqEn` takes effect in the same cycle.
- R7: `empty` is 1 exactly when `level` is 0.
- R8: `popStrobe` is 1 exactly when `serIdle` is 1 and the queue is not empty. Each strobe cycle removes one byte, which is presented on `popData` during that cycle.
- R9: The queue accepts 32 writes with no pops before it reports full. The 33rd write is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Host write strobe |
| wrData | input | 32 | Host write word; only bits [7:0] are stored |
| thresh | input | 6 | Low-water level, counted as bytes still queued |
| irqEn | input | 1 | Interrupt enable |
| serIdle | input | 1 | Shifter is idle and can take a byte |
| popStrobe | output | 1 | A byte is taken by the shifter this cycle |
| popData | output | 8 | Oldest queued byte |
| level | output | 6 | Number of bytes queued |
| txReady | output | 1 | Queued bytes are at or below the low-water level |
| txIrq | output | 1 | Ready status gated by the enable |
| empty | output | 1 | Queue holds no bytes |
| overflow | output | 1 | Sticky flag: a write arrived while full |

## Verification
`popStrobe` and `popData` are combinational from the current inputs and the stored state, so they are due in the same cycle as `serIdle`. `txIrq` also answers `irqEn` and `thresh` in that cycle. `level`, `empty`, `txReady` and `overflow` change one rising edge after the write or pop that moved them. The bench drives every input just after a falling edge and samples one time unit later. At that point the reference queue has already absorbed the previous rising edge, so each output is compared exactly in the cycle it is due.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;
  // Strobes issued by the control path to the storage path for one cycle.
  typedef struct packed {
    logic push;   // write wrByte at the write pointer, advance it
    logic pop;    // advance the read pointer
  } fifoStrobe_t;
endpackage

// File: rtl/txFifoData.sv
module txFifoData
  import txfifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrByte,
  output logic [DATA_W-1:0] rdByte,
  output logic [ADDR_W-1:0] wrPtr,
  output logic [ADDR_W-1:0] rdPtr
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Pointers wrap naturally because DEPTH is a power of two.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= wrByte;
  end

  // First-word fall-through: the head byte is always presented.
  assign rdByte = mem[rdPtr];

  initial begin
    assert (DEPTH == (1 << ADDR_W)) else $error("DEPTH must be a power of two");
  end
endmodule

// File: rtl/txFifoCtrl.sv
module txFifoCtrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             serIdle,
  input  logic [CNT_W-1:0] thresh,
  input  logic             irqEn,
  output fifoStrobe_t      strobe,
  output logic [CNT_W-1:0] level,
  output logic             popStrobe,
  output logic             txReady,
  output logic             txIrq,
  output logic             empty,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic full;
  logic pushOk;
  logic popOk;

  assign full   = (level == FULL_CNT);
  assign empty  = (level == '0);
  assign pushOk = wrValid && !full;
  assign popOk  = serIdle && !empty;

  always_comb begin
    strobe      = '0;
    strobe.push = pushOk;
    strobe.pop  = popOk;
  end

  assign popStrobe = popOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      level <= '0;
    end else begin
      unique case ({pushOk, popOk})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                overflow <= 1'b0;
    else if (wrValid && full) overflow <= 1'b1;
  end

  // The low-water level counts bytes still waiting, not free slots.
  assign txReady = (level <= thresh);
  assign txIrq   = txReady && irqEn;

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_CNT);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && full && !serIdle) |=> (level == FULL_CNT) && overflow);

  assert_pop_decrements_R8: assert property (@(posedge clk) disable iff (!rstN)
    (popStrobe && !wrValid) |=> (level == $past(level) - 1'b1));
endmodule

// File: rtl/txLowWaterFifo.sv
module txLowWaterFifo
  import txfifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int HOST_W = 32,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [HOST_W-1:0] wrData,
  input  logic [CNT_W-1:0]  thresh,
  input  logic              irqEn,
  input  logic              serIdle,
  output logic              popStrobe,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  level,
  output logic              txReady,
  output logic              txIrq,
  output logic              empty,
  output logic              overflow
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  txFifoCtrl #(.DEPTH(DEPTH)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .serIdle   (serIdle),
    .thresh    (thresh),
    .irqEn     (irqEn),
    .strobe    (strobe),
    .level     (level),
    .popStrobe (popStrobe),
    .txReady   (txReady),
    .txIrq     (txIrq),
    .empty     (empty),
    .overflow  (overflow)
  );

  txFifoData #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uData (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrByte (wrData[DATA_W-1:0]),
    .rdByte (popData),
    .wrPtr  (wrPtr),
    .rdPtr  (rdPtr)
  );

  // Pointer distance in storage must match the count kept by control.
  assert_ptr_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    ADDR_W'(wrPtr - rdPtr) == level[ADDR_W-1:0]);
endmodule

// File: tb/txLowWaterFifo_test.sv
module txLowWaterFifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int CNT_W      = 6;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic             rstN;
  logic             wrValid;
  logic [31:0]      wrData;
  logic [CNT_W-1:0] thresh;
  logic             irqEn;
  logic             serIdle;
  logic             popStrobe;
  logic [7:0]       popData;
  logic [CNT_W-1:0] level;
  logic             txReady;
  logic             txIrq;
  logic             empty;
  logic             overflow;

  txLowWaterFifo uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .thresh(thresh), .irqEn(irqEn), .serIdle(serIdle),
    .popStrobe(popStrobe), .popData(popData), .level(level),
    .txReady(txReady), .txIrq(txIrq), .empty(empty), .overflow(overflow)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;
  byte unsigned q[$];
  bit ovf = 0;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare against the reference queue, then advance it.
  task automatic step(bit wr, logic [31:0] d, bit idle, int thr, bit en);
    bit expPop;
    bit wasFull;
    @(negedge clk);
    wrValid = wr; wrData = d; serIdle = idle; thresh = CNT_W'(thr); irqEn = en;
    #1;
    expPop = idle && (q.size() > 0);
    chk("R8", "popStrobe", int'(popStrobe), int'(expPop));
    if (expPop) chk("R2", "popData", int'(popData), int'(q[0]));
    chk("R4", "level", int'(level), q.size());
    chk("R7", "empty", int'(empty), int'(q.size() == 0));
    chk("R5", "txReady", int'(txReady), int'(q.size() <= thr));
    chk("R6", "txIrq", int'(txIrq), int'((q.size() <= thr) && en));
    chk("R3", "overflow", int'(overflow), int'(ovf));
    wasFull = (q.size() == DEPTH);
    if (expPop) void'(q.pop_front());
    if (wr) begin
      if (!wasFull) q.push_back(d[7:0]);
      else ovf = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 0; wrValid = 0; wrData = '0; thresh = 6'd8; irqEn = 0; serIdle = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state, no activity
    step(0, 0, 0, 8, 0);
    chk("R1", "reset popStrobe", int'(popStrobe), 0);
    // R2: upper bits of the host word are discarded
    for (int i = 0; i < 5; i++) step(1, 32'hDEAD_0000 | (32'h11 * i), 0, 8, 1);
    // R9: fill to the depth with no pops
    while (q.size() < DEPTH) step(1, 32'hFFFF_FF00 | q.size(), 0, 8, 1);
    chk("R9", "level at full", q.size(), DEPTH);
    // R3: writes while full are dropped
    step(1, 32'h0000_00EE, 0, 8, 1);
    step(1, 32'h0000_00EF, 0, 8, 1);
    chk("R3", "level after full writes", int'(level), DEPTH);
    // R5/R6: drain across the low-water level, enable toggled
    for (int i = 0; i < 36; i++) step(0, 0, 1, 8, (i / 4) % 2);
    // R4: simultaneous push and pop
    step(1, 32'h55, 0, 8, 1);
    for (int i = 0; i < 10; i++) step(1, 32'h60 + i, 1, 8, 1);
    // boundary thresholds 0 and 32
    for (int i = 0; i < 40; i++) step(i < 33, 32'h70 + i, i >= 33, 32, 1);
    for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 1);
    // mixed pattern
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | lf[1], {lf, lf}, lf[2] & lf[3], int'(lf[9:4]) % 33, lf[5]);
    end
    for (int i = 0; i < 40; i++) step(0, 0, 1, 4, 1);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule